// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

This block moves a list of registers between a register file and memory, one 32-bit word per memory access. It walks the register list from the lowest-numbered selected register upward and places each word at the next ascending address. A single transfer is either a load (memory to registers) or a store (registers to memory). Stack-style transfers use the same engine: a push stores below the base, and a pop loads upward from it.

An interrupt request may arrive while a transfer is running. The sequencer never cuts a memory access short. It samples the interrupt only when a response arrives and further registers remain. If the request is high at that point, the sequencer stops and reports the index of the next register as a continuation value. A later command with the resume flag and that value finishes the remaining registers. Double-word transfers, and every transfer while the no-continuation control pin is high, report zero instead. Their replay starts again from the first word, so the low word is accessed a second time.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. The caller holds `cmd_valid` and all command fields steady until a cycle in which both are high. Memory requests follow the same rule. Once `mem_req_valid` rises, the request stays asserted with a stable address, direction and data until `mem_req_ready` is high. Only one access is outstanding, and its response returns on `mem_rsp_valid`, which has no back-pressure.

Top module: `mrt_seq`

## Requirements
- R1: The selected registers (bits set in `cmd_list`, bit i meaning register i) are transferred in ascending index order. The word for the register of rank k (0 for the lowest selected register) uses address base + 4k.
- R2: A load (`cmd_store`=0) writes each response word into its register through `rf_we`/`rf_waddr`/`rf_wdata` in the response cycle. A store (`cmd_store`=1) sends the value read at `rf_raddr` as `mem_wdata` with `mem_we`=1.
- R3: `irq` is sampled only in a cycle where `mem_rsp_valid` completes a beat and at least one register remains. A request already issued always completes. After a stop, `abandoned` pulses for one cycle and no further request is issued. An `irq` at the final beat does not prevent completion.
- R4: On a continuable stop, `cont_out` (valid while `abandoned` is high) holds the index of the next register still to be transferred. This value is never zero.
- R5: A command with `cmd_resume`=1 and a nonzero `cmd_cont` transfers only the selected registers with index ≥ `cmd_cont`. Addresses are recomputed from the full list as in R1. A `cmd_cont` of zero transfers the whole list.
- R6: In double-word mode (`cmd_dword`=1), a stop reports `cont_out`=0 and `cmd_cont` is ignored, so the replay begins from the first word again.
- R7: While `cfg_no_cont` is high at command acceptance, every transfer behaves as in R6: a stop reports 0 and `cmd_cont` is ignored.
- R8: With `cmd_descend`=1 (push), the lowest selected register is placed at base − 4N, where N is the number of selected registers. Ranks ascend from there, and the writeback value is base − 4N.
- R9: `done` pulses for one cycle when the whole list has completed. `wb_addr` then holds base + 4N (or base − 4N for a push). A stopped transfer never raises `done`.
- R10: An empty list (after any resume masking) raises `done` in the cycle after acceptance and issues no memory request.
- R11: `cmd_ready` is high only while idle. A memory request not yet accepted holds its valid and address unchanged. At most one access is outstanding.
- R12: `done` and `abandoned` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_no_cont | input | 1 | Disable continuation; stops always restart from the start |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_base | input | 32 | Base address |
| cmd_list | input | 16 | Register selection list |
| cmd_store | input | 1 | 1 = store to memory, 0 = load from memory |
| cmd_dword | input | 1 | Double-word mode, never continuable |
| cmd_descend | input | 1 | Push addressing below the base |
| cmd_resume | input | 1 | Command continues a stopped transfer |
| cmd_cont | input | 4 | Continuation register index for a resume |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the access |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data of the completed access |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| irq | input | 1 | Interrupt request |
| done | output | 1 | Transfer completed (pulse) |
| abandoned | output | 1 | Transfer stopped by interrupt (pulse) |
| cont_out | output | 4 | Continuation value, valid with `abandoned` |
| wb_addr | output | 32 | Base writeback value, valid with `done` |

## Verification
The hardest situation to reach is an interrupt that arrives while a response is outstanding and is then sampled at a boundary that still has registers left. This must happen under memory back-pressure and with varying response latency. The bench's memory model raises `irq` on the cycle after it accepts a chosen beat number and holds it until that beat's response. This places the request exactly in flight, and a rotating ready and latency pattern changes the timing from beat to beat. Each stop is followed by a resume or a replay. The continuation case resumes at a gap in the list, and the double-word and disabled-continuation cases must access the low word twice. A final case raises `irq` on the last beat, where completion must still win.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_DONE,
    ST_STOP
  } seq_state_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/mrt_lsb.sv
// Index of the lowest set bit of a vector (0 when empty).
module mrt_lsb #(
  parameter  int NREG = 16,
  localparam int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mrt_span.sv
// Start address, writeback value and skip mask for a new command.
module mrt_span import mrt_pkg::*; #(
  parameter  int NREG = 16,
  parameter  int AW   = 32,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = IW + 1
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic            descend,
  input  logic            use_cont,
  input  logic [IW-1:0]   start_idx,
  output logic [NREG-1:0] below,
  output logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   wb_addr
);
  logic [CW-1:0] n_sel, k_skip;
  logic [AW-1:0] n_bytes, k_bytes;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_below
    assign below[gi] = use_cont && (start_idx > IW'(gi));
  end

  always_comb begin
    n_sel  = '0;
    k_skip = '0;
    for (int i = 0; i < NREG; i++) begin
      n_sel  = n_sel  + CW'(list[i]);
      k_skip = k_skip + CW'(list[i] & below[i]);
    end
  end

  assign n_bytes    = AW'(n_sel)  << WORD_SHIFT;
  assign k_bytes    = AW'(k_skip) << WORD_SHIFT;
  assign start_addr = descend ? (base - n_bytes + k_bytes) : (base + k_bytes);
  assign wb_addr    = descend ? (base - n_bytes) : (base + n_bytes);
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq import mrt_pkg::*; #(
  parameter  int NREG = 16,
  parameter  int AW   = 32,
  parameter  int DW   = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_no_cont,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_base,
  input  logic [NREG-1:0] cmd_list,
  input  logic            cmd_store,
  input  logic            cmd_dword,
  input  logic            cmd_descend,
  input  logic            cmd_resume,
  input  logic [IW-1:0]   cmd_cont,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  input  logic            irq,
  output logic            done,
  output logic            abandoned,
  output logic [IW-1:0]   cont_out,
  output logic [AW-1:0]   wb_addr
);
  seq_state_e      state_q;
  logic [NREG-1:0] mask_q, rest, mask_start, below;
  logic [AW-1:0]   addr_q, wb_q, start_addr, wb_calc;
  logic [IW-1:0]   cont_q, cur_idx, nxt_idx;
  logic            store_q, replay_q, use_cont, accept;

  assign accept   = cmd_valid && cmd_ready;
  assign use_cont = cmd_resume && !cmd_dword && !cfg_no_cont && (cmd_cont != '0);

  mrt_span #(.NREG(NREG), .AW(AW)) u_span (
    .list      (cmd_list),
    .base      (cmd_base),
    .descend   (cmd_descend),
    .use_cont  (use_cont),
    .start_idx (cmd_cont),
    .below     (below),
    .start_addr(start_addr),
    .wb_addr   (wb_calc)
  );

  assign mask_start = cmd_list & ~below;
  assign rest       = mask_q & (mask_q - NREG'(1));

  mrt_lsb #(.NREG(NREG)) u_cur (.vec(mask_q), .idx(cur_idx));
  mrt_lsb #(.NREG(NREG)) u_nxt (.vec(rest),   .idx(nxt_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      addr_q   <= '0;
      wb_q     <= '0;
      cont_q   <= '0;
      store_q  <= 1'b0;
      replay_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          mask_q   <= mask_start;
          addr_q   <= start_addr;
          wb_q     <= wb_calc;
          store_q  <= cmd_store;
          replay_q <= cmd_dword || cfg_no_cont;
          state_q  <= (mask_start == '0) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_RSP;
        ST_RSP: if (mem_rsp_valid) begin
          mask_q <= rest;
          addr_q <= addr_q + (AW'(1) << WORD_SHIFT);
          if (rest == '0) begin
            state_q <= ST_DONE;
          end else if (irq) begin
            state_q <= ST_STOP;
            cont_q  <= replay_q ? '0 : nxt_idx;
          end else begin
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_addr      = addr_q;
  assign mem_we        = store_q;
  assign mem_wdata     = rf_rdata;
  assign rf_raddr      = cur_idx;
  assign rf_we         = (state_q == ST_RSP) && mem_rsp_valid && !store_q;
  assign rf_waddr      = cur_idx;
  assign rf_wdata      = mem_rdata;
  assign done          = (state_q == ST_DONE);
  assign abandoned     = (state_q == ST_STOP);
  assign cont_out      = cont_q;
  assign wb_addr       = wb_q;
endmodule

// File: rtl/mrt_seq_chk.sv
module mrt_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rsp_valid,
  input logic          rf_we,
  input logic          done,
  input logic          abandoned
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R11
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R11
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid); // R11
  AST_STOP_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    abandoned |-> $past(mem_rsp_valid)); // R3
  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    abandoned |=> !mem_req_valid); // R3
  AST_LOAD_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_rsp_valid); // R2
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abandoned)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_ABN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abandoned |=> !abandoned); // R12
endmodule

bind mrt_seq mrt_seq_chk #(.AW(AW)) u_mrt_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_addr     (mem_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .rf_we        (rf_we),
  .done         (done),
  .abandoned    (abandoned)
);

// File: tb/test_mrt_seq.sv
`timescale 1ns/1ps
module test_mrt_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_no_cont = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic        cmd_store = 1'b0, cmd_dword = 1'b0, cmd_descend = 1'b0, cmd_resume = 1'b0;
  logic [3:0]  cmd_cont = '0;
  logic        mem_req_valid, mem_req_ready, mem_we, mem_rsp_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_raddr, rf_waddr, cont_out;
  logic [31:0] rf_rdata, rf_wdata, wb_addr;
  logic        rf_we, irq, done, abandoned;

  always #2.5 clk = ~clk;

  mrt_seq i_mrt_seq (
    .clk(clk), .rst_n(rst_n), .cfg_no_cont(cfg_no_cont),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_list(cmd_list), .cmd_store(cmd_store), .cmd_dword(cmd_dword),
    .cmd_descend(cmd_descend), .cmd_resume(cmd_resume), .cmd_cont(cmd_cont),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .irq(irq),
    .done(done), .abandoned(abandoned), .cont_out(cont_out), .wb_addr(wb_addr)
  );

  // Bench-side register file and memory, changed only through the ports.
  logic [31:0] rf_b [16];
  logic [31:0] mem_b [256];
  // Reference model state.
  logic [31:0] mrf [16];
  logic [31:0] mmem [256];
  logic [31:0] q_addr[$], q_wd[$], q_rval[$];
  logic        q_we[$];
  int          q_rreg[$];

  int checks = 0, errors = 0, cyc = 0, beat = 0, irq_beat = 0, lat = 0;
  bit pend = 0, pwe = 0, finished = 0;
  logic [7:0]  pa;
  logic [31:0] pwd;

  assign rf_rdata = rf_b[rf_raddr];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: rotating ready and latency, irq raised while a chosen beat is in flight.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; irq <= 1'b0; pend <= 0;
      mem_rdata <= '0;
    end else begin
      mem_req_ready <= (cyc % 3) != 1;
      mem_rsp_valid <= 1'b0;
      if (mem_rsp_valid) irq <= 1'b0;
      if (rf_we) rf_b[rf_waddr] <= rf_wdata;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rdata <= mem_b[pa];
          if (pwe) mem_b[pa] <= pwd;
          pend <= 0;
        end else lat <= lat - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1; pa <= mem_addr[9:2]; pwe <= mem_we; pwd <= mem_wdata;
        lat <= cyc % 3;
        beat <= beat + 1;
        if (beat + 1 == irq_beat) irq <= 1'b1;
      end
    end
  end

  // Per-clock comparison against the model's expected access stream.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) chk(!cmd_ready, "R11 ready low while busy", 32'(cmd_ready), 0);
      if (done || abandoned) chk(!(done && abandoned), "R12 done/abandoned exclusive", 32'({done, abandoned}), 0);
      if (mem_req_valid && mem_req_ready) begin
        if (q_addr.size() == 0) chk(0, "R3 unexpected request", mem_addr, 0);
        else begin
          logic [31:0] ea, ewd; logic ewe;
          ea = q_addr.pop_front(); ewe = q_we.pop_front(); ewd = q_wd.pop_front();
          chk(mem_addr == ea, "R1 access address", mem_addr, ea);
          chk(mem_we == ewe, "R2 access direction", 32'(mem_we), 32'(ewe));
          if (ewe) chk(mem_wdata == ewd, "R2 store data", mem_wdata, ewd);
        end
      end
      if (rf_we) begin
        if (q_rreg.size() == 0) chk(0, "R2 unexpected register write", 32'(rf_waddr), 0);
        else begin
          int er; logic [31:0] ev;
          er = q_rreg.pop_front(); ev = q_rval.pop_front();
          chk(int'(rf_waddr) == er, "R2 load register", 32'(rf_waddr), 32'(er));
          chk(rf_wdata == ev, "R2 load data", rf_wdata, ev);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run(input string tag, input logic [15:0] list, input logic [31:0] base,
                     input bit st, input bit dw, input bit ds, input bit rs,
                     input logic [3:0] ct, input int irqb, input bit nocont);
    int regs[$];
    int n, k, beats, cycles;
    bit honor, stopped;
    logic [31:0] a0, ewb;
    logic [3:0]  econt;
    honor = rs && !dw && !nocont && (ct != 0);
    n = 0; k = 0;
    for (int i = 0; i < 16; i++) if (list[i]) begin
      n++;
      if (honor && i < int'(ct)) k++; else regs.push_back(i);
    end
    a0  = ds ? base - 32'(4 * n) + 32'(4 * k) : base + 32'(4 * k);
    ewb = ds ? base - 32'(4 * n) : base + 32'(4 * n);
    beats = (irqb > 0 && irqb < regs.size()) ? irqb : regs.size();
    stopped = beats < regs.size();
    econt = (stopped && !dw && !nocont) ? 4'(regs[beats]) : 4'd0;
    for (int j = 0; j < beats; j++) begin
      logic [31:0] a; a = a0 + 32'(4 * j);
      q_addr.push_back(a); q_we.push_back(st); q_wd.push_back(mrf[regs[j]]);
      if (st) mmem[a[9:2]] = mrf[regs[j]];
      else begin
        mrf[regs[j]] = mmem[a[9:2]];
        q_rreg.push_back(regs[j]); q_rval.push_back(mmem[a[9:2]]);
      end
    end
    @(posedge clk); #1;
    irq_beat = irqb; beat = 0; cfg_no_cont = nocont;
    cmd_list = list; cmd_base = base; cmd_store = st; cmd_dword = dw;
    cmd_descend = ds; cmd_resume = rs; cmd_cont = ct; cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cycles = 0;
    do begin
      @(negedge clk); cycles++;
      if (cycles > 3000) begin
        chk(0, {tag, " watchdog"}, 0, 1);
        summary();
      end
    end while (!(done || abandoned));
    if (stopped) begin
      chk(abandoned && !done, {tag, " R3 stop reported"}, 32'({done, abandoned}), 32'b01);
      chk(cont_out == econt, {tag, (econt != 0) ? " R4 continuation value" : " R6/R7 zero continuation"},
          32'(cont_out), 32'(econt));
    end else begin
      chk(done && !abandoned, {tag, " R9 completion reported"}, 32'({done, abandoned}), 32'b10);
      chk(wb_addr == ewb, {tag, " R9 writeback value"}, wb_addr, ewb);
    end
    if (regs.size() == 0) chk(cycles == 1, {tag, " R10 empty list latency"}, 32'(cycles), 1);
    @(negedge clk);
    chk(!done && !abandoned, {tag, " R12 one-cycle pulse"}, 32'({done, abandoned}), 0);
    chk(q_addr.size() == 0 && q_rreg.size() == 0, {tag, " R1 all expected accesses seen"},
        32'(q_addr.size() + q_rreg.size()), 0);
    begin
      bit same; same = 1;
      for (int i = 0; i < 16; i++) if (rf_b[i] !== mrf[i]) same = 0;
      for (int i = 0; i < 256; i++) if (mem_b[i] !== mmem[i]) same = 0;
      chk(same, {tag, " R2 register file and memory contents"}, 32'(same), 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin rf_b[i] = 32'hA000_0000 + 32'(i * 32'h111); mrf[i] = rf_b[i]; end
    for (int i = 0; i < 256; i++) begin mem_b[i] = 32'h5000_0000 + 32'(i); mmem[i] = mem_b[i]; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !mem_req_valid && !done && !abandoned, "R11 reset state",
        32'({cmd_ready, mem_req_valid, done, abandoned}), 32'b1000);
    // run(tag, list, base, store, dword, descend, resume, cont, irq_beat, no_cont)
    run("load ascending",      16'h00F1, 32'h040, 0, 0, 0, 0, 4'd0, 0, 0); // R1 R2
    run("store sparse",        16'h8421, 32'h100, 1, 0, 0, 0, 4'd0, 0, 0); // R2
    run("empty list",          16'h0000, 32'h080, 0, 0, 0, 0, 4'd0, 0, 0); // R10
    run("load stopped",        16'h0F0F, 32'h180, 0, 0, 0, 0, 4'd0, 3, 0); // R3 R4
    run("load resumed",        16'h0F0F, 32'h180, 0, 0, 0, 1, 4'd8, 0, 0); // R5
    run("resume at gap",       16'h0F0F, 32'h180, 0, 0, 0, 1, 4'd6, 0, 0); // R5
    run("resume zero",         16'h0F0F, 32'h180, 0, 0, 0, 1, 4'd0, 0, 0); // R5
    run("resume past end",     16'h000F, 32'h0C0, 0, 0, 0, 1, 4'd9, 0, 0); // R10 R5
    run("dword stopped",       16'h0003, 32'h0E0, 1, 1, 0, 0, 4'd0, 1, 0); // R6
    run("dword replay",        16'h0003, 32'h0E0, 1, 1, 0, 1, 4'd1, 0, 0); // R6
    run("no-cont stopped",     16'h00FF, 32'h240, 0, 0, 0, 0, 4'd0, 2, 1); // R7
    run("no-cont replay",      16'h00FF, 32'h240, 0, 0, 0, 1, 4'd2, 0, 1); // R7
    run("push stopped",        16'h4030, 32'h300, 1, 0, 1, 0, 4'd0, 2, 0); // R8 R4
    run("push resumed",        16'h4030, 32'h300, 1, 0, 1, 1, 4'd14, 0, 0); // R8 R5
    run("pop",                 16'h4030, 32'h2F4, 0, 0, 0, 0, 4'd0, 0, 0); // R8
    run("irq on last beat",    16'h0111, 32'h020, 0, 0, 0, 0, 4'd0, 3, 0); // R3
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "global watchdog", 0, 1);
    summary();
  end
endmodule